// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an external digital signal by counting its rising edges over a fixed gate window. The window is derived from the system clock. A prescaler produces a slow tick. A timebase counter wraps after a fixed number of those ticks. A gate counter closes the window after a set number of timebase wraps. With the default settings the gate lasts 128 × 256 × 256 system clocks. At 16 MHz that is 0.524288 s, so each count stands for about 1.907349 Hz. The intended input range reaches roughly 500 kHz.

A one-cycle start pulse clears every counter and opens the gate. The measured input passes through a two-flop synchroniser and a rising-edge detector. Detected edges feed a narrow primary counter, and each time that counter wraps it increments an upper extension register. When the gate closes, edge counting stops in that same cycle. The timebase halts, and the combined value (upper field above, primary field below) is frozen on the count output. The done flag is raised and held with the result until the next start. A start that arrives during a measurement is dropped.

Top module: `gated_freq_counter`

## Requirements
- R1: While and after reset, count is 0, done is 0 and busy is 0.
- R2: A start pulse while not busy makes busy 1, done 0 and count 0 from the next cycle.
- R3: busy stays high for exactly PRESCALE × 2^TB_WIDTH × GATE_OVF consecutive cycles after an accepted start.
- R4: Only rising transitions of sig_in are counted; a pulse of any width and any duty adds exactly one to the count.
- R5: The count is {upper, primary}: the primary field is LO_WIDTH bits wide, and each wrap of the primary field adds one to the upper field of HI_WIDTH bits, so results beyond 2^LO_WIDTH come out exact.
- R6: In the cycle that busy falls, done rises. busy and done are never 1 together.
- R7: After a measurement, done and count hold their values until the next start, whatever sig_in does.
- R8: A start pulse while busy is ignored: the gate length and the final count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears counters and opens the gate |
| sig_in | input | 1 | Asynchronous signal being measured |
| count | output | LO_WIDTH+HI_WIDTH | Frozen edge count of the last gate |
| done | output | 1 | Result valid, held until next start |
| busy | output | 1 | Gate open |

## Verification
The effects of a start show one cycle after the sampling edge: busy, done and the cleared count are checked at the first falling clock edge after it. busy is then sampled at every falling edge until it drops, and that number must equal the gate length. done and the frozen count are checked at the falling edge where busy is first seen low. The synchroniser and edge detector delay each input edge by about three cycles. For that reason the bench places every input edge at least four cycles after the start and at least ten cycles before the gate closes, so the expected count is simply the number of pulses driven. The bench sweeps pulse counts from zero upward under several duty patterns on a short gate and a narrow primary field.

// File: rtl/gfc_pkg.sv
// Package: shared types for the gated frequency counter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package gfc_pkg;

    // Measurement phase of the control logic.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GATE = 2'd1,
        PH_HELD = 2'd2
    } phase_t;

endpackage

// File: rtl/gfc_edge_sync.sv
// Module: gfc_edge_sync
// Brings an asynchronous input into the clock domain through a chain of
// SYNC_STAGES flops, then emits a one-cycle pulse per rising transition.
// Assumes the input stays high and low for at least two clocks each.
module gfc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last;

    // Shift the raw input along the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], sig_async};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~last;

    // R4: one input transition yields one pulse, never two in a row.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/gfc_gate_timer.sv
// Module: gfc_gate_timer
// Produces the gate window: a prescaler divides the clock by PRESCALE, a
// TB_WIDTH-bit timebase counts the resulting ticks, and a gate counter
// preloaded on load closes the gate after GATE_OVF timebase wraps.
// Assumes load and run are never both high.
module gfc_gate_timer #(
    parameter int PRESCALE = 128,
    parameter int TB_WIDTH = 8,
    parameter int GATE_OVF = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic close
);
    localparam int GW = (GATE_OVF > 1) ? $clog2(GATE_OVF) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(GATE_OVF - 1);

    logic          tick;
    logic [TB_WIDTH-1:0] tb;
    logic          tb_wrap;
    logic [GW-1:0] gcnt;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre;

            // Divide the system clock down to the timebase tick.
            always_ff @(posedge clk) begin
                if (!rst_n || load)  pre <= '0;
                else if (run)        pre <= (pre == P_LAST) ? '0 : pre + 1'b1;
            end

            assign tick = run && (pre == P_LAST);
        end else begin : g_nodiv
            assign tick = run;
        end
    endgenerate

    // Count ticks in the timebase; it wraps silently.
    always_ff @(posedge clk) begin
        if (!rst_n || load) tb <= '0;
        else if (tick)      tb <= tb + 1'b1;
    end

    assign tb_wrap = tick && (tb == '1);

    // Count down timebase wraps until the gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gcnt <= '0;
        else if (load)                  gcnt <= G_LAST;
        else if (tb_wrap && gcnt != '0) gcnt <= gcnt - 1'b1;
    end

    assign close = tb_wrap && (gcnt == '0);

    // R3: the gate counter only ever moves down while the gate runs.
    a_r3_gate_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> gcnt <= $past(gcnt));

endmodule

// File: rtl/gfc_edge_counter.sv
// Module: gfc_edge_counter
// Counts increments in a LO_WIDTH-bit primary counter whose wraps advance a
// HI_WIDTH-bit upper register, and freezes {upper, primary} on capture.
// Assumes clear and capture are never both high.
module gfc_edge_counter #(
    parameter int LO_WIDTH = 16,
    parameter int HI_WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         inc,
    input  logic                         capture,
    output logic [LO_WIDTH+HI_WIDTH-1:0] result
);
    logic [LO_WIDTH-1:0] lo;
    logic [HI_WIDTH-1:0] hi;

    // Advance the primary counter on each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) lo <= '0;
        else if (inc)        lo <= lo + 1'b1;
    end

    // Extend the count each time the primary counter wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)       hi <= '0;
        else if (inc && lo == '1)  hi <= hi + 1'b1;
    end

    // Freeze the combined value when the gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) result <= '0;
        else if (capture)    result <= {hi, lo};
    end

    // R5: a primary wrap carries exactly one into the upper field.
    a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && inc && lo == '1) |=> (hi == $past(hi) + 1'b1) && (lo == '0));

endmodule

// File: rtl/gated_freq_counter.sv
// Module: gated_freq_counter (top)
// Counts rising edges of sig_in over a gate of PRESCALE * 2^TB_WIDTH *
// GATE_OVF clocks opened by start; holds the count and done until the next
// start. Assumes sig_in is below a quarter of the clock rate.
module gated_freq_counter
    import gfc_pkg::*;
#(
    parameter int PRESCALE = 128,
    parameter int TB_WIDTH = 8,
    parameter int GATE_OVF = 256,
    parameter int LO_WIDTH = 16,
    parameter int HI_WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         sig_in,
    output logic [LO_WIDTH+HI_WIDTH-1:0] count,
    output logic                         done,
    output logic                         busy
);
    phase_t phase;
    logic   accept;
    logic   gate_close;
    logic   rise;

    assign accept = start && (phase != PH_GATE);

    // Step through idle, gate open and result held.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= PH_IDLE;
        else if (accept)     phase <= PH_GATE;
        else if (gate_close) phase <= PH_HELD;
    end

    assign busy = (phase == PH_GATE);
    assign done = (phase == PH_HELD);

    gfc_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (sig_in),
        .rise      (rise)
    );

    gfc_gate_timer #(
        .PRESCALE (PRESCALE),
        .TB_WIDTH (TB_WIDTH),
        .GATE_OVF (GATE_OVF)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .run   (busy),
        .close (gate_close)
    );

    gfc_edge_counter #(
        .LO_WIDTH (LO_WIDTH),
        .HI_WIDTH (HI_WIDTH)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .inc     (busy && rise && !gate_close),
        .capture (gate_close),
        .result  (count)
    );

    // R2: an accepted start opens the gate on the next cycle.
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R6: the result flag rises exactly as the gate closes.
    a_r6_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: gate open and result held are exclusive.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7: a held result stays put until a new start.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(count)));

    // R8: a start during the gate does not restart or end it.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !gate_close) |=> busy);

endmodule

// File: tb/tb_gated_freq_counter.sv
// Bench: short gate (4 * 8 * 4 = 128 cycles) and a 4-bit primary field so
// that the upper-field carry is reached. Expected counts are the number of
// pulses driven well inside the gate.
module tb_gated_freq_counter;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int T  = 3;
    localparam int G  = 4;
    localparam int LO = 4;
    localparam int HI = 4;
    localparam int N  = P * (1 << T) * G;
    localparam int LEAD = 4;
    localparam int TAIL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sig_in = 1'b0;
    logic [LO+HI-1:0] count;
    logic done;
    logic busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    gated_freq_counter #(
        .PRESCALE (P), .TB_WIDTH (T), .GATE_OVF (G),
        .LO_WIDTH (LO), .HI_WIDTH (HI)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .sig_in (sig_in),
        .count (count), .done (done), .busy (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One measurement: n pulses, hi cycles high and lo low each; optional
    // extra start pulse at gate cycle extra_at (0 = none).
    task automatic measure(input int hi, input int lo, input int n, input int extra_at);
        int bc;
        int off;
        int per;
        per = hi + lo;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy", int'(busy), 1);
        chk("R2 done", int'(done), 0);
        chk("R2 count", int'(count), 0);
        bc = 1;
        while (bc <= N + 4) begin
            off = bc - LEAD;
            sig_in = (off >= 0 && off < n * per && (off % per) < hi);
            start = (extra_at != 0 && bc == extra_at);
            @(negedge clk);
            start = 1'b0;
            if (busy) bc++;
            else break;
        end
        sig_in = 1'b0;
        chk("R3 gate length", bc, N);
        chk("R6 done at close", int'(done), 1);
        chk("R6 busy low", int'(busy), 0);
        if (n >= (1 << LO)) chk("R5 extended count", int'(count), n);
        else if (extra_at != 0) chk("R8 count", int'(count), n);
        else chk("R4 rising count", int'(count), n);
        // Idle edges must not disturb the held result.
        for (int k = 0; k < 6; k++) begin
            sig_in = 1'b1; @(negedge clk);
            @(negedge clk);
            sig_in = 1'b0; @(negedge clk);
            @(negedge clk);
        end
        chk("R7 held count", int'(count), n);
        chk("R7 held done", int'(done), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy idle", int'(busy), 0);
        chk("R1 done idle", int'(done), 0);

        for (int m = 0; m < 5; m++) begin
            int h;
            int l;
            int mx;
            h = (m == 0) ? 1 : (m == 1) ? 1 : (m == 2) ? 2 : (m == 3) ? 3 : 1;
            l = (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 1 : (m == 3) ? 3 : 5;
            mx = (N - LEAD - TAIL) / (h + l);
            for (int n = 0; n <= mx; n += (m == 0) ? 1 : 3)
                measure(h, l, n, 0);
        end
        // R8: start pulses in mid gate are dropped.
        measure(1, 1, 20, 50);
        measure(2, 2, 7, 2);
        measure(1, 1, 30, N - 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual %0d cycles expected below 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule